// File: doc/BRIEF.md
# Transfer Status Queue with Interrupt

This block sits between a USB serial interface engine and the processor. Each time the engine finishes with a data buffer, it pushes a completion record: the endpoint number, whether the token was IN or OUT/SETUP, and which of the two ping-pong buffer banks was used. The records wait in a four-entry queue. The oldest record is shown to software through an 8-bit read-only status byte. A transfer-complete flag is raised whenever a record is on display.

Software reads the status byte while the flag is high, then writes a one to clear the flag. That clear removes the displayed record from the queue. If more records are waiting, the flag comes back exactly three cycles later with the next record showing. If none are waiting, the flag stays low, and the byte must then be treated as stale. When all four slots are occupied, the block tells the engine to answer any further endpoint request with NAK.

The flag is run by a three-state machine:
- `ST_IDLE`: flag low, waiting for a record.
- `ST_SHOW`: flag high, head record valid.
- `ST_REARM`: flag low, counting off the re-arm delay after a clear.

Its transitions are:
- `IDLE->SHOW` when the queue is non-empty.
- `SHOW->REARM` on a clear, which also pops the queue.
- `REARM->SHOW` when the delay ends with records left.
- `REARM->IDLE` when the delay ends with the queue empty.

Top module: `xfer_status_queue`

## Requirements
- R1: Reset empties the queue, drives `xfer_flag` low and drives `nak_req` low. After reset, the first pushed record is the one displayed.
- R2: `stat_reg` has this layout:
  - bit 7 reads 0;
  - bits 6:3 hold the endpoint number;
  - bit 2 is 1 for an IN token and 0 for OUT/SETUP;
  - bit 1 is 1 for the odd bank and 0 for the even bank;
  - bit 0 reads 0.
- R3: Records are displayed strictly oldest first.
- R4: When a record is pushed into an empty, idle queue on clock edge k, `xfer_flag` is high after edge k+1 and low after edge k.
- R5: A `flag_clr` pulse sampled while `xfer_flag` is high drops the flag on that edge and removes exactly one record.
- R6: After such a clear on edge c, the flag stays low after edges c, c+1 and c+2. After edge c+3 it is high if records remain, and it stays low if the queue is empty.
- R7: A `flag_clr` pulse sampled while `xfer_flag` is low removes no record.
- R8: `nak_req` is high exactly when four records are held.
- R9: A push while four records are held is dropped, and the held records are unchanged.
- R10: When the queue is not full, a push and a pop on the same edge leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Engine completed a buffer; record on push_* is stored |
| push_ep | input | 4 | Endpoint number of the completion |
| push_in | input | 1 | 1 = IN token, 0 = OUT/SETUP |
| push_odd | input | 1 | 1 = odd bank, 0 = even bank |
| flag_clr | input | 1 | Write-1-to-clear pulse for the transfer-complete flag |
| stat_reg | output | 8 | Status byte showing the oldest record |
| xfer_flag | output | 1 | Transfer-complete flag |
| nak_req | output | 1 | Queue full; engine must NAK new requests |

## Verification
The bench pushes every one of the 64 possible endpoint/direction/bank records through the queue, four at a time, and checks the byte layout and the ordering. A layout or ordering slip would show as a mismatched status byte.

The re-arm delay is checked cycle by cycle. A machine that re-armed early or late, or that re-armed on an empty queue, would show the flag in the wrong cycle.

Several stimuli target the occupancy bookkeeping:
- a push into a full queue;
- clears issued while the flag is low, both during the re-arm window and while idle;
- a push coinciding with a pop.

A design that wrapped over an old record, popped on an ignored clear, or lost a record on the simultaneous edge would drain the wrong number of records or the wrong ones. A mid-run reset confirms that stale records do not survive.

// File: rtl/xsq_pkg.sv
package xsq_pkg;
    parameter int EP_W = 4;

    typedef struct packed {
        logic [EP_W-1:0] ep;
        logic            is_in;
        logic            odd;
    } xsq_rec_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHOW  = 2'd1,
        ST_REARM = 2'd2
    } xsq_state_e;
endpackage

// File: rtl/xsq_fifo.sv
module xsq_fifo
    import xsq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  xsq_rec_t                   din,
    output xsq_rec_t                   head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    xsq_rec_t         slots [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic             do_push, do_pop;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = slots[rd_ptr];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slots[gi] <= '0;
            end else if (do_push && wr_ptr == PTR_W'(gi)) begin
                slots[gi] <= din;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R9: occupancy never exceeds the queue depth
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R9: a dropped push leaves the write pointer where it was
    a_r9_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> $stable(wr_ptr));
endmodule

// File: rtl/xsq_flag_fsm.sv
module xsq_flag_fsm
    import xsq_pkg::*;
#(
    parameter int REARM_DLY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic empty,
    output logic flag,
    output logic pop
);
    localparam int CW = (REARM_DLY > 1) ? $clog2(REARM_DLY) : 1;
    localparam logic [CW-1:0] CNT_END = CW'(REARM_DLY - 1);

    xsq_state_e state, nxt;
    logic [CW-1:0] cnt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (!empty) nxt = ST_SHOW;
            ST_SHOW:  if (clr) nxt = ST_REARM;
            ST_REARM: if (cnt == CNT_END) nxt = empty ? ST_IDLE : ST_SHOW;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= (state == ST_REARM) ? cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        flag = 1'b0;
        pop  = 1'b0;
        unique case (state)
            ST_SHOW: begin
                flag = 1'b1;
                pop  = clr;
            end
            default: begin
                flag = 1'b0;
                pop  = 1'b0;
            end
        endcase
    end

    // R6: the re-arm counter stays inside the delay window
    a_r6_rearm_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REARM) |-> (cnt <= CNT_END));

    // R5: a clear while shown drops the flag on the next cycle
    a_r5_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && clr) |=> !flag);
endmodule

// File: rtl/xfer_status_queue.sv
module xfer_status_queue
    import xsq_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int REARM_DLY = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_valid,
    input  logic [3:0] push_ep,
    input  logic       push_in,
    input  logic       push_odd,
    input  logic       flag_clr,
    output logic [7:0] stat_reg,
    output logic       xfer_flag,
    output logic       nak_req
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    xsq_rec_t         rec_in, rec_head;
    logic [CNT_W-1:0] occ;
    logic             q_full, q_empty, do_pop;

    assign rec_in = '{ep: push_ep, is_in: push_in, odd: push_odd};

    xsq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_valid),
        .pop   (do_pop),
        .din   (rec_in),
        .head  (rec_head),
        .count (occ),
        .full  (q_full),
        .empty (q_empty)
    );

    xsq_flag_fsm #(.REARM_DLY(REARM_DLY)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flag_clr),
        .empty (q_empty),
        .flag  (xfer_flag),
        .pop   (do_pop)
    );

    assign stat_reg = {1'b0, rec_head.ep, rec_head.is_in, rec_head.odd, 1'b0};
    assign nak_req  = q_full;

    // R4: the flag is only shown over a non-empty queue
    a_r4_flag_has_record: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_flag |-> (occ != '0));

    // R5: a serviced clear removes exactly one record
    a_r5_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_flag && flag_clr && !push_valid) |=> (occ == $past(occ) - 1'b1));

    // R7: a clear while the flag is low removes nothing
    a_r7_clear_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_flag && flag_clr && !push_valid) |=> $stable(occ));

    // R8: NAK request while full persists through a refused push
    a_r8_nak_full: assert property (@(posedge clk) disable iff (!rst_n)
        (nak_req && push_valid && !flag_clr) |=> (occ == FULL_CNT));

    // R2: unused status bits read zero
    a_r2_pad_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_reg[7] == 1'b0) && (stat_reg[0] == 1'b0));
endmodule

// File: tb/xfer_status_queue_tb.sv
module xfer_status_queue_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_valid = 1'b0;
    logic [3:0] push_ep = '0;
    logic       push_in = 1'b0;
    logic       push_odd = 1'b0;
    logic       flag_clr = 1'b0;
    logic [7:0] stat_reg;
    logic       xfer_flag;
    logic       nak_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    xfer_status_queue u_dut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ep(push_ep),
        .push_in(push_in), .push_odd(push_odd), .flag_clr(flag_clr),
        .stat_reg(stat_reg), .xfer_flag(xfer_flag), .nak_req(nak_req)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] enc(input int idx);
        logic [5:0] v;
        v = idx[5:0];
        return {1'b0, v[5:2], v[1], v[0], 1'b0};
    endfunction

    task automatic push_rec(input int idx);
        logic [5:0] v;
        v = idx[5:0];
        push_valid = 1'b1;
        push_ep    = v[5:2];
        push_in    = v[1];
        push_odd   = v[0];
        step();
        push_valid = 1'b0;
    endtask

    task automatic drain_one(input logic [7:0] exp_val, input bit more);
        chk(xfer_flag == 1'b1, "R4 flag shown", int'(xfer_flag), 1);
        chk(stat_reg == exp_val, "R2/R3 status byte", int'(stat_reg), int'(exp_val));
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        chk(xfer_flag == 1'b0, "R5 flag drops on clear", int'(xfer_flag), 0);
        step();
        chk(xfer_flag == 1'b0, "R6 low c+1", int'(xfer_flag), 0);
        step();
        chk(xfer_flag == 1'b0, "R6 low c+2", int'(xfer_flag), 0);
        step();
        chk(xfer_flag == more, "R6 rearm at c+3", int'(xfer_flag), int'(more));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        step();
        step();
        rst_n = 1'b1;
        chk(xfer_flag == 1'b0, "R1 reset flag", int'(xfer_flag), 0);
        chk(nak_req == 1'b0, "R1 reset nak", int'(nak_req), 0);

        // Sweep every record value, four per group (R2, R3, R4, R8, R9)
        for (int blk = 0; blk < 16; blk++) begin
            push_rec(blk * 4);
            chk(xfer_flag == 1'b0, "R4 flag low after push edge", int'(xfer_flag), 0);
            push_rec(blk * 4 + 1);
            chk(xfer_flag == 1'b1, "R4 flag high one edge later", int'(xfer_flag), 1);
            push_rec(blk * 4 + 2);
            chk(nak_req == 1'b0, "R8 nak low at three", int'(nak_req), 0);
            push_rec(blk * 4 + 3);
            chk(nak_req == 1'b1, "R8 nak high at four", int'(nak_req), 1);
            push_rec((blk * 4 + 37) % 64); // R9: dropped while full
            chk(nak_req == 1'b1, "R9 still full", int'(nak_req), 1);
            for (int k = 0; k < 4; k++) begin
                drain_one(enc(blk * 4 + k), k < 3);
                if (k == 0) chk(nak_req == 1'b0, "R8 nak low after pop", int'(nak_req), 0);
            end
        end

        // R7: clears while the flag is low
        push_rec(5);
        push_rec(9);
        step();
        chk(stat_reg == enc(5), "R3 head A", int'(stat_reg), int'(enc(5)));
        flag_clr = 1'b1;
        step();
        step(); // second clear lands in the re-arm window
        flag_clr = 1'b0;
        step();
        step();
        chk(xfer_flag == 1'b1, "R7 rearm after ignored clear", int'(xfer_flag), 1);
        chk(stat_reg == enc(9), "R7 record B kept", int'(stat_reg), int'(enc(9)));
        drain_one(enc(9), 1'b0);
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        push_rec(12);
        step();
        chk(xfer_flag == 1'b1, "R7 idle clear ignored", int'(xfer_flag), 1);
        chk(stat_reg == enc(12), "R7 record C shown", int'(stat_reg), int'(enc(12)));

        // R10: push and pop on the same edge
        push_rec(20);
        push_valid = 1'b1;
        push_ep = 4'hB;
        push_in = 1'b1;
        push_odd = 1'b0;
        flag_clr = 1'b1;
        step();
        push_valid = 1'b0;
        flag_clr = 1'b0;
        step();
        step();
        step();
        drain_one(enc(20), 1'b1);
        drain_one(enc(46), 1'b0);
        chk(nak_req == 1'b0, "R10 nak low after drain", int'(nak_req), 0);

        // R1: mid-run reset discards held records
        push_rec(1);
        push_rec(2);
        push_rec(3);
        push_rec(4);
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        chk(xfer_flag == 1'b0, "R1 flag after reset", int'(xfer_flag), 0);
        chk(nak_req == 1'b0, "R1 nak after reset", int'(nak_req), 0);
        push_rec(63);
        step();
        drain_one(enc(63), 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule